// File: doc/BRIEF.md
# DDR Octal Memory Bus Target

This block is the device side of an eight-bit double-data-rate memory bus. It sits behind an active-low select, a bus clock, eight data lines and a read strobe. It serves a small internal word array. Every transaction opens with a three-cycle header. The header carries the direction, the burst style and a word address. A write stores the single 16-bit word that follows the header. A read waits a fixed number of cycles and then streams words out, with a strobe that the device drives itself. The stream continues until the host lets select go high.

The bus moves one byte on each clock edge, so each clock cycle carries one 16-bit word: the rising-edge byte is the upper half and the falling-edge byte is the lower half. All control runs on the falling edge, after both bytes of a cycle are present. The output bytes are launched so that the strobe edges line up with the data edges. Raising select clears every piece of transaction state at once, but the array contents are kept.

Top module: `octbus_target`

## Requirements
- R1: While `rst_n` is low or `cs_n` is high, `dq_oe` and `rds_oe` are both 0.
- R2: The three cycles after `cs_n` falls form a 48-bit header, most significant word first, each word being {rising-edge byte, falling-edge byte}. Bit 47 = 1 selects a read and 0 a write. Bit 45 = 1 selects a linear burst and 0 a wrapped burst. Bit 46 is reserved. Bits 44:0 hold the word address.
- R3: In a write, the word of cycle 3 is stored at the header address, and `rds_oe` stays 0 for the whole transaction.
- R4: Words that follow the first data word of a write are ignored, and neighbouring array words keep their contents.
- R5: In a read, `rds_oe` is 1 and both `rds_o` and `dq_oe` are 0 for the LAT+1 cycles after the header (cycles 3 to LAT+3). The first data word occupies cycle LAT+4.
- R6: In every data cycle `dq_oe` is 1. While the clock is high, `dq_o` carries the upper byte and `rds_o` is 1. While the clock is low, `dq_o` carries the lower byte and `rds_o` is 0.
- R7: A linear read returns words from consecutive addresses, rolling from the last array word to word 0.
- R8: A wrapped read stays inside the aligned block that holds the start address. The block size is set by `wrap_sel`: 01 gives 8 words (16 bytes), 10 gives 16 words (32 bytes), and 00 or 11 give 32 words (64 bytes). `wrap_sel` is sampled in the last header cycle.
- R9: A linear read ignores `wrap_sel`.
- R10: Address bits above log2(DEPTH) are ignored, so aliased addresses reach the same word.
- R11: A rising `cs_n` at any point, including mid-header, during the latency or mid-burst, immediately drops `dq_oe` and `rds_oe`. The next falling `cs_n` starts a fresh header decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ck | input | 1 | Bus clock; bytes move on both edges |
| cs_n | input | 1 | Active-low select; high ends any transaction |
| dq_i | input | 8 | Byte from the host |
| wrap_sel | input | 2 | Wrapped burst size code |
| dq_o | output | 8 | Byte to the host during reads |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| rds_o | output | 1 | Read strobe, edge-aligned with data |
| rds_oe | output | 1 | Drive enable for the read strobe |

## Verification
The bench builds the block with DEPTH = 64 and LAT = 2. A 64-word array holds two 32-word wrap blocks, so the largest wrap size can be tested in both the lower and the upper block. The same array size lets a linear burst cross from the top of the array back to word 0, and lets an address above 63 be checked for aliasing. A latency of two needs the real wait counter rather than the one-cycle variant, so the bench can count the quiet cycles before the first word.

// File: rtl/octbus_pkg.sv
package octbus_pkg;
   localparam int HDR_WORDS  = 3;
   localparam int WORD_BITS  = 16;
   localparam int READ_BIT   = 15;   // bit 47 of the header, inside the first word
   localparam int LINEAR_BIT = 13;   // bit 45 of the header, inside the first word

   typedef enum logic [2:0] {
      PH_HDR,
      PH_WAIT,
      PH_READ,
      PH_WDATA,
      PH_DONE
   } phase_t;

   // word mask of the wrap block for a size code
   function automatic logic [4:0] wrap_mask(input logic [1:0] sel);
      case (sel)
         2'b01:   return 5'd7;
         2'b10:   return 5'd15;
         default: return 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/octbus_rx.sv
module octbus_rx #(
   parameter int BW = 8
)(
   input  logic          ck,
   input  logic          arst_n,
   input  logic [BW-1:0] dq_i,
   output logic [2*BW-1:0] word
);
   logic [BW-1:0] rise_q;

   // rising-edge byte held for pairing with the falling-edge byte
   always_ff @(posedge ck or negedge arst_n) begin
      if (!arst_n) rise_q <= '0;
      else         rise_q <= dq_i;
   end

   assign word = {rise_q, dq_i};
endmodule

// File: rtl/octbus_next_addr.sv
module octbus_next_addr #(
   parameter int AW = 6
)(
   input  logic [AW-1:0] addr,
   input  logic          lin,
   input  logic [AW-1:0] mask,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] inc;

   assign inc = addr + AW'(1);
   assign nxt = lin ? inc : ((addr & ~mask) | (inc & mask));
endmodule

// File: rtl/octbus_ram.sv
module octbus_ram #(
   parameter int DEPTH = 64,
   parameter int DW    = 16,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          ck,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(negedge ck) begin
      if (we) mem[addr] <= wdata;
      if (re) rdata     <= mem[addr];
   end
endmodule

// File: rtl/octbus_tx.sv
module octbus_tx #(
   parameter int BW = 8
)(
   input  logic            ck,
   input  logic            arst_n,
   input  logic            load,
   input  logic [2*BW-1:0] word,
   output logic [BW-1:0]   dq_o,
   output logic            dq_oe,
   output logic            rds_o
);
   logic [BW-1:0] hi_q, lo_q;
   logic          on_q;

   always_ff @(posedge ck or negedge arst_n) begin
      if (!arst_n) begin
         hi_q <= '0;
         lo_q <= '0;
         on_q <= 1'b0;
      end else begin
         on_q <= load;
         hi_q <= word[2*BW-1:BW];
         lo_q <= word[BW-1:0];
      end
   end

   // upper byte in the high phase, lower byte in the low phase
   assign dq_o  = ck ? hi_q : lo_q;
   assign dq_oe = on_q;
   assign rds_o = ck & on_q;
endmodule

// File: rtl/octbus_target.sv
module octbus_target
   import octbus_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LAT   = 2
)(
   input  logic       rst_n,
   input  logic       ck,
   input  logic       cs_n,
   input  logic [7:0] dq_i,
   input  logic [1:0] wrap_sel,
   output logic [7:0] dq_o,
   output logic       dq_oe,
   output logic       rds_o,
   output logic       rds_oe
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   if (DEPTH < 32 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 32 words");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least one cycle");
   end

   logic                 arst_n;
   logic [WORD_BITS-1:0] word;
   logic [WORD_BITS-1:0] rdata;
   phase_t               phase_q;
   logic [1:0]           hcnt_q;
   logic                 rd_q, lin_q, rvalid_q;
   logic [AW-1:0]        addr_q, mask_q, addr_nxt;
   logic                 wait_done, hdr_last, rd_phase, wr_phase;

   // select high clears every piece of transaction state
   assign arst_n   = rst_n & ~cs_n;
   assign hdr_last = (phase_q == PH_HDR) && (hcnt_q == 2'(HDR_WORDS - 1));
   assign rd_phase = (phase_q == PH_READ);
   assign wr_phase = (phase_q == PH_WDATA);
   assign rds_oe   = (phase_q == PH_WAIT) || rd_phase;

   octbus_rx #(.BW(8)) u_rx (
      .ck     (ck),
      .arst_n (arst_n),
      .dq_i   (dq_i),
      .word   (word)
   );

   always_ff @(negedge ck or negedge arst_n) begin
      if (!arst_n) begin
         phase_q  <= PH_HDR;
         hcnt_q   <= '0;
         rd_q     <= 1'b0;
         lin_q    <= 1'b0;
         addr_q   <= '0;
         mask_q   <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_phase;
         case (phase_q)
            PH_HDR: begin
               // upper address bits fall off the top: aliasing
               addr_q <= AW'({addr_q, word});
               hcnt_q <= hcnt_q + 2'd1;
               if (hcnt_q == 2'd0) begin
                  rd_q  <= word[READ_BIT];
                  lin_q <= word[LINEAR_BIT];
               end
               if (hdr_last) begin
                  mask_q  <= AW'(wrap_mask(wrap_sel));
                  phase_q <= rd_q ? PH_WAIT : PH_WDATA;
               end
            end
            PH_WAIT:  if (wait_done) phase_q <= PH_READ;
            PH_READ:  addr_q  <= addr_nxt;
            PH_WDATA: phase_q <= PH_DONE;
            default:  phase_q <= PH_DONE;
         endcase
      end
   end

   if (LAT == 1) begin : g_lat_one
      assign wait_done = 1'b1;
   end else begin : g_lat_cnt
      logic [CW-1:0] lcnt_q;
      always_ff @(negedge ck or negedge arst_n) begin
         if (!arst_n)
            lcnt_q <= '0;
         else if (hdr_last)
            lcnt_q <= CW'(LAT - 1);
         else if (phase_q == PH_WAIT && lcnt_q != '0)
            lcnt_q <= lcnt_q - CW'(1);
      end
      assign wait_done = (lcnt_q == '0);
   end

   octbus_next_addr #(.AW(AW)) u_nxt (
      .addr (addr_q),
      .lin  (lin_q),
      .mask (mask_q),
      .nxt  (addr_nxt)
   );

   octbus_ram #(.DEPTH(DEPTH), .DW(WORD_BITS)) u_ram (
      .ck    (ck),
      .we    (wr_phase),
      .re    (rd_phase),
      .addr  (addr_q),
      .wdata (word),
      .rdata (rdata)
   );

   octbus_tx #(.BW(8)) u_tx (
      .ck     (ck),
      .arst_n (arst_n),
      .load   (rvalid_q),
      .word   (rdata),
      .dq_o   (dq_o),
      .dq_oe  (dq_oe),
      .rds_o  (rds_o)
   );
endmodule

// File: rtl/octbus_target_chk.sv
module octbus_target_chk #(
   parameter int AW = 6
)(
   input logic          ck,
   input logic          rst_n,
   input logic          arst_n,
   input logic          cs_n,
   input logic          dq_oe,
   input logic          rds_oe,
   input logic          rds_o,
   input logic          rd_phase,
   input logic          wr_phase,
   input logic          lin,
   input logic [AW-1:0] addr,
   input logic [AW-1:0] mask
);
   p_quiet_deselect_r1: assert property (@(posedge ck) disable iff (!rst_n)
      cs_n |-> (!dq_oe && !rds_oe));

   p_no_strobe_write_r3: assert property (@(negedge ck) disable iff (!arst_n)
      wr_phase |-> !rds_oe);

   p_data_with_strobe_r6: assert property (@(negedge ck) disable iff (!arst_n)
      dq_oe |-> (rds_oe && rds_o));

   p_linear_step_r7: assert property (@(negedge ck) disable iff (!arst_n)
      (rd_phase && lin) |=> (!rd_phase || addr == $past(addr) + AW'(1)));

   p_wrap_block_r8: assert property (@(negedge ck) disable iff (!arst_n)
      (rd_phase && !lin) |=> (!rd_phase || (addr & ~mask) == ($past(addr) & ~$past(mask))));
endmodule

bind octbus_target octbus_target_chk #(.AW(AW)) u_chk (
   .ck       (ck),
   .rst_n    (rst_n),
   .arst_n   (arst_n),
   .cs_n     (cs_n),
   .dq_oe    (dq_oe),
   .rds_oe   (rds_oe),
   .rds_o    (rds_o),
   .rd_phase (rd_phase),
   .wr_phase (wr_phase),
   .lin      (lin_q),
   .addr     (addr_q),
   .mask     (mask_q)
);

// File: tb/test_octbus_target.sv
module test_octbus_target;
   localparam int DEPTH = 64;
   localparam int LAT   = 2;

   logic       rst_n = 1'b0;
   logic       ck = 1'b0;
   logic       cs_n = 1'b1;
   logic [7:0] dq_i = '0;
   logic [1:0] wrap_sel = '0;
   logic [7:0] dq_o;
   logic       dq_oe, rds_o, rds_oe;

   int          n_chk = 0;
   int          n_err = 0;
   logic [15:0] model [DEPTH];
   logic [15:0] expq [$];
   string       cur_req = "R7";

   octbus_target #(.DEPTH(DEPTH), .LAT(LAT)) i_octbus_target (
      .rst_n    (rst_n),
      .ck       (ck),
      .cs_n     (cs_n),
      .dq_i     (dq_i),
      .wrap_sel (wrap_sel),
      .dq_o     (dq_o),
      .dq_oe    (dq_oe),
      .rds_o    (rds_o),
      .rds_oe   (rds_oe)
   );

   initial forever #10 ck = ~ck;   // 50 MHz

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: byte on the rising edge, byte on the falling edge
   task automatic send_word(input logic [15:0] w);
      dq_i = w[15:8];
      @(posedge ck); #5;
      dq_i = w[7:0];
      @(negedge ck); #5;
   endtask

   task automatic header(input bit rd, input bit lin, input logic [44:0] a);
      logic [47:0] h;
      h = {rd, 1'b0, lin, a};
      cs_n = 1'b0;
      send_word(h[47:32]);
      send_word(h[31:16]);
      send_word(h[15:0]);
   endtask

   task automatic release_cs();
      #2 cs_n = 1'b1;
      #1 chk(!dq_oe && !rds_oe, "R11 outputs released on select high", {dq_oe, rds_oe}, 0);
      @(negedge ck); #5;
   endtask

   task automatic wr(input logic [44:0] a, input logic [15:0] d, input bit extra);
      header(1'b0, 1'b1, a);
      send_word(d);
      chk(!rds_oe, "R3 strobe undriven in write", rds_oe, 0);
      if (extra) begin
         send_word(~d);   // R4: must be ignored
         chk(!rds_oe, "R3 strobe undriven after write data", rds_oe, 0);
      end
      release_cs();
      model[a[5:0]] = d;
   endtask

   task automatic rd(input logic [44:0] a, input bit lin, input logic [1:0] ws, input int n, input string req);
      logic [5:0] p, m;
      p = a[5:0];
      m = (ws == 2'b01) ? 6'd7 : (ws == 2'b10) ? 6'd15 : 6'd31;
      for (int j = 0; j < n; j++) begin
         expq.push_back(model[p]);
         p = lin ? p + 6'd1 : ((p & ~m) | ((p + 6'd1) & m));
      end
      cur_req  = req;
      wrap_sel = ws;
      header(1'b1, lin, a);
      for (int i = 0; i < LAT + 1; i++) begin
         @(posedge ck); #5;
         chk(!dq_oe && !rds_o && rds_oe, "R5 quiet latency cycle", {dq_oe, rds_o, rds_oe}, 3'b001);
         @(negedge ck); #5;
      end
      for (int j = 0; j < n; j++) begin
         @(posedge ck); #5;
         if (j == 0) chk(dq_oe, "R5 first word in cycle LAT+4", dq_oe, 1);
         @(negedge ck); #5;
      end
      release_cs();
      chk(expq.size() == 0, {req, " all words delivered"}, expq.size(), 0);
      expq.delete();
   endtask

   // monitor: scoreboard pops one expected word per data cycle
   initial forever begin
      logic [7:0] b0, b1;
      logic       s0, s1;
      logic [15:0] e;
      @(posedge ck); #5;
      if (dq_oe) begin
         b0 = dq_o; s0 = rds_o;
         @(negedge ck); #5;
         b1 = dq_o; s1 = rds_o;
         chk(s0 && !s1, "R6 strobe edge-aligned", {s0, s1}, 2'b10);
         if (expq.size() == 0) begin
            chk(1'b0, {cur_req, " unexpected word"}, {b0, b1}, 0);
         end else begin
            e = expq.pop_front();
            chk({b0, b1} == e, {cur_req, " R6 read data"}, {b0, b1}, e);
         end
      end
   end

   initial begin
      #(64'd20 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #5 chk(!dq_oe && !rds_oe, "R1 quiet in reset", {dq_oe, rds_oe}, 0);
      @(negedge ck); @(negedge ck); #5;
      rst_n = 1'b1;
      @(negedge ck); #5;
      chk(!dq_oe && !rds_oe, "R1 quiet while deselected", {dq_oe, rds_oe}, 0);

      // fill the array through R2/R3 writes
      for (int i = 0; i < DEPTH; i++) wr(45'(i), 16'(i * 257 + 16'h1234), 1'b0);

      rd(45'd3, 1'b1, 2'b00, 4, "R2 R7 linear read");
      rd(45'd62, 1'b1, 2'b00, 4, "R7 roll over array end");
      rd(45'd6, 1'b1, 2'b01, 4, "R9 linear ignores wrap_sel");
      rd(45'd5, 1'b0, 2'b01, 6, "R8 wrap 8 words");
      rd(45'd13, 1'b0, 2'b10, 6, "R8 wrap 16 words");
      rd(45'd30, 1'b0, 2'b00, 4, "R8 wrap 32 words low block");
      rd(45'd62, 1'b0, 2'b11, 4, "R8 wrap 32 words high block");

      wr(45'd11, 16'hC0DE, 1'b0);
      wr(45'd10, 16'hBEEF, 1'b1);
      rd(45'd10, 1'b1, 2'b00, 2, "R4 extra write word ignored");

      wr(45'd84, 16'h7777, 1'b0);
      rd(45'd20, 1'b1, 2'b00, 1, "R10 alias of address 84");
      rd(45'h100_0000_0005, 1'b1, 2'b00, 2, "R10 high address bits ignored");

      // R11: abort mid-header, then a fresh transaction
      cs_n = 1'b0;
      send_word(16'h8000);
      release_cs();
      wr(45'd40, 16'h5A5A, 1'b0);
      rd(45'd40, 1'b1, 2'b00, 1, "R11 fresh decode after header abort");

      // R11: abort during read latency
      header(1'b1, 1'b1, 45'd40);
      @(posedge ck); #5;
      chk(rds_oe && !dq_oe, "R5 strobe driven low in latency", {rds_oe, dq_oe}, 2'b10);
      @(negedge ck); #5;
      release_cs();
      rd(45'd41, 1'b1, 2'b00, 3, "R11 read after latency abort");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule